// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregator with Pin Hold

This block gathers interrupt events into one active-high interrupt pin through two tiers of status and enable registers. Secondary events set sticky bits in a secondary status register. The enabled secondary bits are OR-reduced, and the result is gated by a master enable. When that gated result is 1, one bit of a six-bit primary status register is set. The other five primary bits are set by their own event pulses.

The enabled primary bits are OR-reduced and pass through a hold stage to the pin. A pin-enable control bit decides whether the pin follows the OR result or keeps its present level. Software reaches all registers through a simple select, write-strobe and data port, and read data is returned combinationally. Status bits clear when software writes 1 to them.

Software can mask the pin for a while in two ways. It can clear the primary status and then drop pin-enable. Or it can clear the primary enables and then drop pin-enable; this keeps the pending status. To undo either, it restores the register it changed and then raises pin-enable again.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every register reads 0 and `intPin` is 0. Select codes: 0 secondary status, 1 secondary enable, 2 primary status, 3 primary enable, 4 configuration. Any other code reads 0.
- R2: A pulse on `secEvent[i]` sets secondary status bit i at the next clock. The bit stays set until a write to select 0 with data bit i = 1 clears it. If a set and a clear reach the same bit in the same cycle, the set wins.
- R3: The secondary enable register (select 1) stores bits SEC_N-1:0 and the master enable in bit 31. Its other bits read 0.
- R4: When any secondary status bit is set with its enable bit, and master bit 31 is also 1, primary status bit 0 is set at the next clock. With the master bit at 0, bit 0 is never set this way.
- R5: Primary status bit 0 stays set after the secondary condition goes away. Only a write-1 to bit 0 of select 2 clears it.
- R6: A pulse on `priEvent[k]` sets primary status bit k+1 at the next clock. Write-1 clears it, and a set wins over a same-cycle clear.
- R7: While configuration bit 0 (pin-enable) is 1, `intPin` equals, one clock later, the OR of the primary status bits ANDed with their primary enable bits.
- R8: While pin-enable is 0, `intPin` does not change, whatever is written to the status or enable registers and whatever events arrive.
- R9: Clearing the primary enables and then dropping pin-enable keeps the primary status pending. After the enables are rewritten and pin-enable is raised, the pin asserts again.
- R10: A primary status bit whose enable bit is 0 does not assert `intPin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register select |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| secEvent | input | SEC_N | Secondary event pulses |
| priEvent | input | 5 | Primary event pulses for primary bits 5:1 |
| intPin | output | 1 | Interrupt output, active high |

## Verification
A wrong internal state shows up at the ports within a cycle or two. A status bit that fails to latch or clear appears in the very next read of its register. A cascade fault shows in primary status bit 0 one clock after the secondary condition is met. A fault in the hold stage shows on `intPin` one clock after pin-enable or the enabled OR result changes. Because of this, the bench compares the pin and the selected read data against its reference model on every clock. Its stimulus sequences walk through both masking procedures and same-cycle set/clear collisions.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W      = 32;
  localparam int PRI_N       = 6;
  localparam int CASCADE_IDX = 0;
  localparam int MASTER_IDX  = 31;

  typedef enum logic [2:0] {
    SEL_SEC_STAT = 3'd0,
    SEL_SEC_EN   = 3'd1,
    SEL_PRI_STAT = 3'd2,
    SEL_PRI_EN   = 3'd3,
    SEL_HW_CFG   = 3'd4
  } regSelT;

  typedef struct packed {
    logic secStatClr;
    logic secEnWr;
    logic priStatClr;
    logic priEnWr;
    logic cfgWr;
  } ctlStrobeT;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic      [2:0] regSel,
  input  logic            regWrEn,
  output ctlStrobeT       strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (regSelT'(regSel))
        SEL_SEC_STAT: strobes.secStatClr = 1'b1;
        SEL_SEC_EN:   strobes.secEnWr    = 1'b1;
        SEL_PRI_STAT: strobes.priStatClr = 1'b1;
        SEL_PRI_EN:   strobes.priEnWr    = 1'b1;
        SEL_HW_CFG:   strobes.cfgWr      = 1'b1;
        default:      strobes            = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int SEC_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobes,
  input  logic        [2:0] regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic  [SEC_N-1:0] secEvent,
  input  logic  [PRI_N-2:0] priEvent,
  output logic              intPin
);
  logic [SEC_N-1:0] secStatus, secEnBits, secClr;
  logic             masterEn;
  logic [PRI_N-1:0] priStatus, priEnable, priClr, priSet;
  logic             pinEnable, intPinQ;
  logic             secRaise, priAny;

  assign secRaise = masterEn & (|(secStatus & secEnBits));
  assign priAny   = |(priStatus & priEnable);
  assign secClr   = strobes.secStatClr ? regWrData[SEC_N-1:0] : '0;
  assign priClr   = strobes.priStatClr ? regWrData[PRI_N-1:0] : '0;

  always_comb begin
    priSet = '0;
    priSet[CASCADE_IDX] = secRaise;
    for (int k = 0; k < PRI_N - 1; k++) priSet[k + 1] = priEvent[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secStatus <= '0;
      secEnBits <= '0;
      masterEn  <= 1'b0;
      priStatus <= '0;
      priEnable <= '0;
      pinEnable <= 1'b0;
    end else begin
      secStatus <= (secStatus & ~secClr) | secEvent;
      priStatus <= (priStatus & ~priClr) | priSet;
      if (strobes.secEnWr) begin
        secEnBits <= regWrData[SEC_N-1:0];
        masterEn  <= regWrData[MASTER_IDX];
      end
      if (strobes.priEnWr) priEnable <= regWrData[PRI_N-1:0];
      if (strobes.cfgWr)   pinEnable <= regWrData[0];
    end
  end

  // Hold stage: transparent (registered) while pinEnable is 1, frozen otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          intPinQ <= 1'b0;
    else if (pinEnable) intPinQ <= priAny;
  end
  assign intPin = intPinQ;

  always_comb begin
    regRdData = '0;
    case (regSelT'(regSel))
      SEL_SEC_STAT: regRdData[SEC_N-1:0] = secStatus;
      SEL_SEC_EN: begin
        regRdData[SEC_N-1:0]  = secEnBits;
        regRdData[MASTER_IDX] = masterEn;
      end
      SEL_PRI_STAT: regRdData[PRI_N-1:0] = priStatus;
      SEL_PRI_EN:   regRdData[PRI_N-1:0] = priEnable;
      SEL_HW_CFG:   regRdData[0]         = pinEnable;
      default:      regRdData            = '0;
    endcase
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (secEvent != '0) |=> ((secStatus & $past(secEvent)) == $past(secEvent)));
  a_r4_cascade_sets: assert property (@(posedge clk) disable iff (!rstN)
    secRaise |=> priStatus[CASCADE_IDX]);
  a_r5_cascade_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (priStatus[CASCADE_IDX] && !(strobes.priStatClr && regWrData[CASCADE_IDX]))
    |=> priStatus[CASCADE_IDX]);
  a_r7_pin_follows: assert property (@(posedge clk) disable iff (!rstN)
    pinEnable |=> (intPin == $past(priAny)));
  a_r8_pin_holds: assert property (@(posedge clk) disable iff (!rstN)
    !pinEnable |=> $stable(intPin));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int SEC_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic        [2:0] regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic  [SEC_N-1:0] secEvent,
  input  logic  [PRI_N-2:0] priEvent,
  output logic              intPin
);
  ctlStrobeT strobes;

  irq_agg_ctrl u_ctrl (
    .regSel  (regSel),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  irq_agg_dp #(.SEC_N(SEC_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .secEvent  (secEvent),
    .priEvent  (priEvent),
    .intPin    (intPin)
  );
endmodule

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
  localparam int SEC_N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [SEC_N-1:0] secEvent = '0;
  logic [4:0]  priEvent = '0;
  logic        intPin;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  logic [31:0] mSecStat, mSecEn, mPriStat, mPriEn, mCfg;
  logic        mPin;

  irq_agg_top #(.SEC_N(SEC_N)) u_irq_agg_top (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .secEvent(secEvent),
    .priEvent(priEvent), .intPin(intPin)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [2:0] s);
    case (s)
      3'd0: return mSecStat;
      3'd1: return mSecEn;
      3'd2: return mPriStat;
      3'd3: return mPriEn;
      3'd4: return mCfg;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSecStat = 0; mSecEn = 0; mPriStat = 0; mPriEn = 0; mCfg = 0; mPin = 0;
    end else begin
      logic raise, anyPri;
      logic [31:0] secMask;
      secMask = (32'd1 << SEC_N) - 1;
      raise  = ((mSecStat & mSecEn & secMask) != 0) && mSecEn[31];
      anyPri = (mPriStat & mPriEn) != 0;
      if (mCfg[0]) mPin = anyPri;
      if (regWrEn && regSel == 3'd0) mSecStat = mSecStat & ~(regWrData & secMask);
      mSecStat = mSecStat | 32'(secEvent);
      if (regWrEn && regSel == 3'd2) mPriStat = mPriStat & ~(regWrData & 32'h3F);
      mPriStat = mPriStat | {26'd0, priEvent, raise};
      if (regWrEn && regSel == 3'd1) mSecEn = regWrData & (secMask | 32'h8000_0000);
      if (regWrEn && regSel == 3'd3) mPriEn = regWrData & 32'h3F;
      if (regWrEn && regSel == 3'd4) mCfg = regWrData & 32'h1;
    end
  end

  function automatic string selTag(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R10";
      3'd4: return "R8";
      default: return "R1";
    endcase
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      compared++;
      if (intPin !== mPin) begin
        mismatched++;
        $display("FAIL R7 model pin: actual %0b expected %0b at %0t", intPin, mPin, $time);
      end
      compared++;
      if (regRdData !== modelRead(regSel)) begin
        mismatched++;
        $display("FAIL %s model read sel %0d: actual %h expected %h",
                 selTag(regSel), regSel, regRdData, modelRead(regSel));
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    regSel = s; regWrEn = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic expectReg(input logic [2:0] s, input logic [31:0] exp, input string tag);
    regSel = s; #1;
    compared++;
    if (regRdData !== exp) begin
      mismatched++;
      $display("FAIL %s reg %0d: actual %h expected %h", tag, s, regRdData, exp);
    end
  endtask

  task automatic expectPin(input logic exp, input string tag);
    #1;
    compared++;
    if (intPin !== exp) begin
      mismatched++;
      $display("FAIL %s pin: actual %0b expected %0b", tag, intPin, exp);
    end
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    for (int s = 0; s < 8; s++) expectReg(3'(s), 32'd0, "R1");
    expectPin(1'b0, "R1");

    // R3 enable register layout
    wr(3'd1, 32'hFFFF_FFFF);
    expectReg(3'd1, 32'h8000_00FF, "R3");
    wr(3'd1, 32'h0000_0004);            // master off
    // R4: no cascade without master
    secEvent = 8'h04; tick(); secEvent = '0;
    expectReg(3'd0, 32'h04, "R2");
    tick(); tick();
    expectReg(3'd2, 32'h00, "R4");
    // master on -> cascade
    wr(3'd1, 32'h8000_0004);
    tick();
    expectReg(3'd2, 32'h01, "R4");
    // R5: drop secondary condition, bit 0 sticky
    wr(3'd0, 32'h04);
    expectReg(3'd0, 32'h00, "R2");
    tick(); tick();
    expectReg(3'd2, 32'h01, "R5");
    wr(3'd2, 32'h01);
    expectReg(3'd2, 32'h00, "R5");

    // R2 set wins over same-cycle clear
    regSel = 3'd0; regWrEn = 1'b1; regWrData = 32'h10; secEvent = 8'h10;
    tick(); regWrEn = 1'b0; secEvent = '0; regWrData = '0;
    expectReg(3'd0, 32'h10, "R2");
    wr(3'd0, 32'hFF);
    wr(3'd2, 32'h3F);                   // drop cascade that bit 4 may raise
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h3F);

    // R6 primary events and set-wins
    priEvent = 5'b00100; tick(); priEvent = '0;
    expectReg(3'd2, 32'h08, "R6");
    regSel = 3'd2; regWrEn = 1'b1; regWrData = 32'h08; priEvent = 5'b00100;
    tick(); regWrEn = 1'b0; priEvent = '0; regWrData = '0;
    expectReg(3'd2, 32'h08, "R6");
    wr(3'd2, 32'h3F);

    // R10 masked bit does not assert pin
    wr(3'd3, 32'h08);                   // only bit 3 enabled
    wr(3'd4, 32'h1);
    priEvent = 5'b00001; tick(); priEvent = '0;  // sets bit 1
    tick(); tick();
    expectPin(1'b0, "R10");
    // R7 follow: enabled bit 3
    priEvent = 5'b00100; tick(); priEvent = '0;   // status at this edge
    expectPin(1'b0, "R7");
    tick();
    expectPin(1'b1, "R7");

    // R8 hold: drop pin-enable, clear status, pin stays
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h3F);
    tick(); tick();
    expectPin(1'b1, "R8");
    wr(3'd3, 32'h00);
    tick();
    expectPin(1'b1, "R8");
    wr(3'd4, 32'h1);
    tick();
    expectPin(1'b0, "R7");

    // R9 mask by enable, keep status pending
    wr(3'd3, 32'h3F);
    priEvent = 5'b10000; tick(); priEvent = '0;
    tick();
    expectPin(1'b1, "R9");
    wr(3'd3, 32'h00);
    wr(3'd4, 32'h0);
    expectPin(1'b0, "R9");
    priEvent = 5'b00010; tick(); priEvent = '0;
    tick();
    expectPin(1'b0, "R9");
    expectReg(3'd2, 32'h24, "R9");
    wr(3'd3, 32'h3F);
    wr(3'd4, 32'h1);
    tick();
    expectPin(1'b1, "R9");

    // mixed traffic, compared each clock
    for (int i = 0; i < 300; i++) begin
      secEvent = 8'((i * 37) >> 3);
      priEvent = 5'((i * 13) % 7 == 0 ? (i >> 2) : 0);
      regSel   = 3'(i % 6);
      regWrEn  = (i % 5 == 0);
      regWrData = (i % 2 == 0) ? 32'h8000_00FF ^ 32'(i) : 32'(i * 91);
      tick();
    end
    regWrEn = 1'b0; secEvent = '0; priEvent = '0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule